// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This unit takes two IEEE-754 binary64 operands and reports how they are ordered. The result is a one-hot four-bit condition code, plus two invalid-operation flags. A mode pin selects the unordered compare or the ordered compare. A second pin carries the invalid-operation trap-enable bit, which the caller reads from its status register. The unit only computes these values. Updating the status register, delivering traps and decoding instructions are left to the surrounding logic.

Each operand is first sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. The verdict then comes from a fixed chain of tests, in this order:
1. any NaN;
2. both operands zero;
3. signs differ;
4. magnitude classes differ;
5. finite magnitudes.

Finite magnitudes are compared as one unsigned integer made of the exponent and fraction fields. No subtractor is used.

Operands enter on a valid/ready stream, and results leave on another valid/ready stream. There is one register stage between them.
- A request is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- Its result is shown from the next cycle and held unchanged until `out_ready` is seen high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input at once, and nothing is dropped.

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the condition code is 4'b0001. Bit 0 is "unordered", and no other bit is set.
- R2: If either operand is a signalling NaN (fraction MSB 0, fraction nonzero), `flag_snan` is 1 in both modes. In every other case it is 0.
- R3: `flag_vc` is 1 only in ordered mode (`ordered_mode`=1) with a NaN operand, and then only when `inv_trap_en` is 1 or at least one operand is a quiet NaN (fraction MSB 1). When the only NaNs are signalling and `inv_trap_en` is 0, it stays 0.
- R4: Two zeros give "equal" (4'b0010) whatever their signs.
- R5: When the signs differ and the operands are not both zero, a negative first operand gives "less" (4'b1000) and a positive one gives "greater" (4'b0100).
- R6: With equal signs and different classes, magnitude ranks as infinity above finite nonzero above zero. The result is inverted when both operands are negative.
- R7: Two infinities of the same sign give "equal".
- R8: Two finite nonzero operands of the same sign are ordered by magnitude, with subnormals counted as finite nonzero. Identical magnitudes give "equal".
- R9: Whenever `out_valid` is 1, exactly one bit of `cc` is set. The layout is {less, greater, equal, unordered} on bits 3..0.
- R10: A request accepted at a clock edge presents its result in the next cycle. The result and flags hold stable while `out_valid`=1 and `out_ready`=0. `in_ready` is low exactly when the output register is full and not being drained.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| ordered_mode | input | 1 | 1 = ordered compare, 0 = unordered compare |
| inv_trap_en | input | 1 | Invalid-operation trap-enable bit from the status register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| cc | output | 4 | One-hot condition code {less, greater, equal, unordered} |
| flag_snan | output | 1 | Signalling-NaN invalid flag |
| flag_vc | output | 1 | Invalid-compare flag (ordered mode only) |

## Verification
The bench builds the unit with its default binary64 widths (11 exponent bits, 52 fraction bits). This lets the reference model read each non-NaN operand as a native double and order it by real-number comparison, which shares no structure with the integer magnitude path in the RTL. At these widths, the directed vectors reach:
- signed zeros and subnormal-versus-zero pairs;
- the largest finite value against infinity;
- every mix of quiet and signalling NaN under both modes and both trap-enable values.

Random output back-pressure exercises the hold and stall rules.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUB  = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_QNAN = 3'd4,
    FC_SNAN = 3'd5
  } fclass_e;

  // condition code bit positions
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_UN = 0;
  localparam int CC_W  = 4;

  // magnitude rank of a non-NaN class: zero < finite nonzero < infinity
  function automatic logic [1:0] mag_rank(input fclass_e c);
    case (c)
      FC_ZERO:         return 2'd0;
      FC_SUB, FC_NORM: return 2'd1;
      default:         return 2'd2;
    endcase
  endfunction

  function automatic logic is_nan(input fclass_e c);
    return (c == FC_QNAN) || (c == FC_SNAN);
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] operand,
  output logic              sign,
  output fclass_e           cls,
  output logic [MAG_W-1:0]  mag
);

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign sign    = operand[WORD_W-1];
  assign expo    = operand[MAG_W-1:FRAC_W];
  assign frac    = operand[FRAC_W-1:0];
  assign mag     = operand[MAG_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;

  always_comb begin
    if (exp_max) begin
      if (!frac_nz)              cls = FC_INF;
      else if (frac[FRAC_W-1])   cls = FC_QNAN;
      else                       cls = FC_SNAN;
    end else if (exp_min) begin
      cls = frac_nz ? FC_SUB : FC_ZERO;
    end else begin
      cls = FC_NORM;
    end
  end

endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic             sign_a,
  input  fclass_e          cls_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  fclass_e          cls_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             ordered,
  input  logic             trap_en,
  output logic [CC_W-1:0]  cc,
  output logic             snan_flag,
  output logic             vc_flag
);

  logic       nan_any;
  logic       snan_any;
  logic       qnan_any;
  logic       zero_both;
  logic [1:0] rank_a;
  logic [1:0] rank_b;
  logic       abs_lt;
  logic       abs_gt;

  assign nan_any   = is_nan(cls_a) || is_nan(cls_b);
  assign snan_any  = (cls_a == FC_SNAN) || (cls_b == FC_SNAN);
  assign qnan_any  = (cls_a == FC_QNAN) || (cls_b == FC_QNAN);
  assign zero_both = (cls_a == FC_ZERO) && (cls_b == FC_ZERO);
  assign rank_a    = mag_rank(cls_a);
  assign rank_b    = mag_rank(cls_b);

  // magnitude order: class rank first, then the packed exponent/fraction
  always_comb begin
    if (rank_a != rank_b) begin
      abs_lt = rank_a < rank_b;
      abs_gt = rank_a > rank_b;
    end else begin
      abs_lt = mag_a < mag_b;
      abs_gt = mag_a > mag_b;
    end
  end

  always_comb begin
    cc        = '0;
    snan_flag = 1'b0;
    vc_flag   = 1'b0;
    if (nan_any) begin
      cc[CC_UN] = 1'b1;
      snan_flag = snan_any;
      vc_flag   = ordered && (trap_en || qnan_any);
    end else if (zero_both) begin
      cc[CC_EQ] = 1'b1;
    end else if (sign_a != sign_b) begin
      if (sign_a) cc[CC_LT] = 1'b1;
      else        cc[CC_GT] = 1'b1;
    end else if (abs_lt) begin
      if (sign_a) cc[CC_GT] = 1'b1;
      else        cc[CC_LT] = 1'b1;
    end else if (abs_gt) begin
      if (sign_a) cc[CC_LT] = 1'b1;
      else        cc[CC_GT] = 1'b1;
    end else begin
      cc[CC_EQ] = 1'b1;
    end
  end

endmodule

// File: rtl/fcmp_stage.sv
module fcmp_stage #(
  parameter int PAY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);

  logic             full_q;
  logic [PAY_W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
      data_q <= up_data;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int PAY_W  = CC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              ordered_mode,
  input  logic              inv_trap_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CC_W-1:0]   cc,
  output logic              flag_snan,
  output logic              flag_vc
);

  localparam int N_OPS = 2;

  logic [WORD_W-1:0] opnd   [N_OPS];
  logic              sgn    [N_OPS];
  fclass_e           cls    [N_OPS];
  logic [MAG_W-1:0]  mag    [N_OPS];

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .operand (opnd[gi]),
      .sign    (sgn[gi]),
      .cls     (cls[gi]),
      .mag     (mag[gi])
    );
  end

  logic [CC_W-1:0]  cc_c;
  logic             snan_c;
  logic             vc_c;
  logic [PAY_W-1:0] res_q;

  fcmp_decide #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
    .sign_a    (sgn[0]),
    .cls_a     (cls[0]),
    .mag_a     (mag[0]),
    .sign_b    (sgn[1]),
    .cls_b     (cls[1]),
    .mag_b     (mag[1]),
    .ordered   (ordered_mode),
    .trap_en   (inv_trap_en),
    .cc        (cc_c),
    .snan_flag (snan_c),
    .vc_flag   (vc_c)
  );

  fcmp_stage #(.PAY_W(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  ({cc_c, snan_c, vc_c}),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res_q)
  );

  assign cc        = res_q[PAY_W-1:2];
  assign flag_snan = res_q[1];
  assign flag_vc   = res_q[0];

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] cc,
  input logic       flag_snan,
  input logic       flag_vc
);

  // R9: exactly one condition bit while a result is shown
  p_onehot_cc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cc) == 1);

  // R2: invalid flags appear only with an unordered verdict
  p_flags_unord_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cc[0] |-> !flag_snan && !flag_vc);

  // R10: held result does not change under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cc) && $stable(flag_snan) && $stable(flag_vc));

  // R10: an accepted request is visible the next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: full and stalled output blocks the input
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

bind fcmp_unit fcmp_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .cc        (cc),
  .flag_snan (flag_snan),
  .flag_vc   (flag_vc)
);

// File: tb/sim_fcmp_unit.sv
`timescale 1ns/1ps
module sim_fcmp_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        ordered_mode = 1'b0;
  logic        inv_trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  cc;
  logic        flag_snan;
  logic        flag_vc;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit bp_on  = 1'b0;
  bit done   = 1'b0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  fcmp_unit u0 (
    .clk, .rst_n, .in_valid, .in_ready, .op_a, .op_b, .ordered_mode,
    .inv_trap_en, .out_valid, .out_ready, .cc, .flag_snan, .flag_vc
  );

  localparam logic [63:0] PZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] MAXF  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] DEN1  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DEN2  = 64'h000F_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN  = 64'h0010_0000_0000_0000;

  function automatic bit nan_of(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  // reference: {cc, snan, vc}
  function automatic logic [5:0] model(input logic [63:0] a, b, input bit ord, te);
    bit na = nan_of(a), nb = nan_of(b);
    bit qa = na && a[51], qb = nb && b[51];
    bit sa = na && !a[51], sb = nb && !b[51];
    real ra, rb;
    if (na || nb) return {4'b0001, sa | sb, ord & (te | qa | qb)};
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb)      return 6'b1000_00;
    else if (ra > rb) return 6'b0100_00;
    else              return 6'b0010_00;
  endfunction

  function automatic string tag_of(input logic [63:0] a, b);
    if (nan_of(a) || nan_of(b)) return "R1/R2/R3";
    if (a[62:0] == 0 && b[62:0] == 0) return "R4";
    if (a[63] != b[63]) return "R5";
    if (a[62:0] == PINF[62:0] && b[62:0] == PINF[62:0]) return "R7";
    if (a[62:52] == 11'h7FF || b[62:52] == 11'h7FF || a[62:0] == 0 || b[62:0] == 0) return "R6";
    return "R8";
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  // scoreboard and cycle-accurate handshake model, sampled at negedge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(out_valid == (exp_q.size() > 0), "R10 out_valid", 64'(out_valid), 64'(exp_q.size() > 0));
      check(in_ready == (exp_q.size() == 0 || out_ready), "R10 in_ready", 64'(in_ready),
            64'(exp_q.size() == 0 || out_ready));
      if (out_valid && exp_q.size() > 0) begin
        check($countones(cc) == 1, "R9 onehot", 64'(cc), 64'(exp_q[0][5:2]));
        if (out_ready) begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({cc, flag_snan, flag_vc} == e, t, 64'({cc, flag_snan, flag_vc}), 64'(e));
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(op_a, op_b, ordered_mode, inv_trap_en));
        tag_q.push_back(tag_of(op_a, op_b));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready <= bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic send(input logic [63:0] a, b, input bit ord, te);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; ordered_mode = ord; inv_trap_en = te;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  task automatic both_modes(input logic [63:0] a, b);
    for (int m = 0; m < 4; m++) send(a, b, m[0], m[1]);
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] x = {$urandom, $urandom};
    case ($urandom_range(0, 7))
      0: x[62:0] = 0;
      1: x[62:52] = 11'h000;
      2: x[62:52] = 11'h7FF;
      3: begin x[62:52] = 11'h7FF; x[51:0] = 0; end
      default: ;
    endcase
    return x;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R11 in_ready in reset", 64'(in_ready), 64'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid after reset", 64'(out_valid), 64'd0);

    // R4 signed zeros
    both_modes(PZERO, NZERO);
    both_modes(NZERO, PZERO);
    both_modes(NZERO, NZERO);
    // R5 sign differs
    send(NZERO, DEN1, 0, 0);
    send(PZERO, DEN1 | NZERO, 0, 0);
    send(ONE, NINF, 1, 0);
    send(NINF, PZERO, 0, 1);
    // R6 class ranking, both signs
    send(PINF, MAXF, 0, 0);
    send(NINF, MAXF | NZERO, 0, 0);
    send(DEN1, PZERO, 0, 0);
    send(NZERO, DEN1 | NZERO, 0, 0);
    send(PZERO, PINF, 1, 1);
    // R7 infinities
    send(PINF, PINF, 1, 0);
    send(NINF, NINF, 0, 0);
    send(PINF, NINF, 0, 0);
    // R8 finite magnitudes incl. subnormals
    send(ONE, TWO, 0, 0);
    send(ONE | NZERO, TWO | NZERO, 0, 0);
    send(DEN2, MINN, 0, 0);
    send(DEN1, DEN2, 0, 0);
    send(DEN2 | NZERO, DEN1 | NZERO, 0, 0);
    send(ONE, ONE, 1, 1);
    send(DEN2, DEN2, 0, 0);
    // R1 R2 R3 NaN mixes in all mode/enable combinations
    both_modes(QNAN, ONE);
    both_modes(ONE, SNAN);
    both_modes(SNAN, SNAN | NZERO);
    both_modes(QNAN, SNAN);
    both_modes(PINF, QNAN | NZERO);
    both_modes(PZERO, SNAN);

    bp_on = 1'b1;
    for (int i = 0; i < 600; i++)
      send(rnd_op(), rnd_op(), $urandom_range(0, 1), $urandom_range(0, 1));
    @(posedge clk); #1 in_valid = 1'b0;
    bp_on = 1'b0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R10 drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule